// File: doc/BRIEF.md
# Multi-channel PWM clock generator

This block supplies four independent rate enables, one per PWM channel, all in a single system-clock domain. A machine tick is derived from the system clock with a selectable divide. A free-running prescaler, advanced by that tick, offers four tap rates at the same time to every channel. Each channel picks one of the four taps or an external pin. The pin is synchronized and edge-detected before use, and a channel can only see the pin it is paired with.

The chosen source events drive an 8-bit auto-reload down-counter in each channel. A reload value N gives one output tick for every N+1 source events, so N = 0 passes every event through. The source select and the reload value are taken into the channel only when its counter reloads. A new setting therefore never cuts short the period that is already running. The outputs are one-cycle enables that a downstream duty-cycle generator samples. This block generates no derived clocks.

Top module: `pwm_clkgen_top`

## Requirements
- R1: The machine tick occurs once every 4, 64 or 1024 system clocks for `mdiv_sel` = 0, 1 or 2. The value 3 behaves as 2.
- R2: Source select values 0, 1, 2 and 3 give source events at the machine tick divided by 1, 4, 16 and 64. Every event of a slower tap coincides with an event of each faster tap.
- R3: Source select value 4 picks external pin `c mod 2` for channel c. Pin 0 serves channels 0 and 2, and pin 1 serves channels 1 and 3.
- R4: While a pin's enable bit is 0, that pin produces no source events, and a channel using it produces no ticks.
- R5: A pin passes through two synchronizer flops and one edge flop. One source event is produced per falling edge of the synchronized pin, and the channel tick follows in the next cycle.
- R6: A latched reload value N yields exactly one tick per N+1 source events. N = 0 gives a tick for every event, and N = 255 gives one tick per 256 events.
- R7: The select and reload inputs are sampled only on the source event that finds the channel count at zero. A change made during a period leaves that period's length unchanged.
- R8: Source select values 5 to 7 produce no source events, so the channel issues no ticks.
- R9: Each tick lasts exactly one clock, is registered, and appears the cycle after the source event that caused it.
- R10: While `rst_n` is low, all counters, the synchronizers and the latched selects clear to zero, and all ticks read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdiv_sel | input | 2 | Machine-tick divide setting (0: /4, 1: /64, 2 or 3: /1024) |
| ext_pin | input | 2 | Asynchronous external source pins |
| ext_en | input | 2 | Per-pin enable; 0 makes the pin inactive |
| src_sel | input | 12 | Per-channel source select, 3 bits each, channel 0 in the low bits |
| reload | input | 32 | Per-channel reload value, 8 bits each, channel 0 in the low bits |
| ch_tick | output | 4 | One-cycle rate enables, one per channel |

## Verification
A wrong prescaler or machine-tick count changes the spacing of the ticks on every channel that uses a tap. At the fastest setting this appears within a few clocks, and at the slowest tap it appears within one 65536-clock period. A corrupted down-counter or latched select shows as a tick one or more events early or late, at the channel's next reload. A fault in the pin synchronizer shifts the tick by a cycle from the third cycle after a falling edge. Because the reference model is compared on every clock, each such fault is reported in the cycle it first reaches `ch_tick`.

// File: rtl/pwmcg_pkg.sv
package pwmcg_pkg;
   localparam int SEL_W     = 3;
   localparam int NUM_TAPS  = 4;
   localparam int NUM_SRC   = NUM_TAPS + 1;
   typedef logic [SEL_W-1:0] src_sel_t;
   localparam src_sel_t SRC_EXT = src_sel_t'(NUM_TAPS);
endpackage

// File: rtl/pwmcg_mtick.sv
module pwmcg_mtick #(
   parameter int BASE_LOG2 = 2,
   parameter int STEP_LOG2 = 4,
   parameter int NUM_SET   = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] div_sel,
   output logic       mtick
);
   localparam int CW = BASE_LOG2 + STEP_LOG2 * (NUM_SET - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb begin
      lim = '0;
      for (int i = 0; i < NUM_SET; i++) begin
         if (int'(div_sel) == i || (i == NUM_SET - 1 && int'(div_sel) >= NUM_SET))
            lim = CW'((1 << (BASE_LOG2 + STEP_LOG2 * i)) - 1);
      end
   end

   assign mtick = (cnt >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (mtick) cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pwmcg_prescale.sv
module pwmcg_prescale #(
   parameter int NUM_TAPS = 4,
   parameter int TAP_LOG2 = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mtick,
   output logic [NUM_TAPS-1:0] taps
);
   localparam int PW = TAP_LOG2 * (NUM_TAPS - 1);

   logic [PW-1:0] pc;

   always_ff @(posedge clk) begin
      if (!rst_n)     pc <= '0;
      else if (mtick) pc <= pc + 1'b1;
   end

   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      if (t == 0) begin : g_base
         assign taps[t] = mtick;
      end else begin : g_div
         assign taps[t] = mtick && (&pc[TAP_LOG2*t-1:0]);
      end
   end
endmodule

// File: rtl/pwmcg_pinsync.sv
module pwmcg_pinsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic en,
   output logic fall
);
   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], pin};
   end

   assign fall = en && sh[STAGES] && !sh[STAGES-1];
endmodule

// File: rtl/pwmcg_chan.sv
module pwmcg_chan #(
   parameter int RELOAD_W = 8,
   parameter int SEL_W    = 3,
   parameter int NUM_SRC  = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  src_ev,
   input  logic [SEL_W-1:0]    sel_in,
   input  logic [RELOAD_W-1:0] reload_in,
   output logic                tick,
   output logic                ev_o,
   output logic [SEL_W-1:0]    act_sel_o
);
   logic [RELOAD_W-1:0] cnt;
   logic [SEL_W-1:0]    act_sel;
   logic                ev;
   logic                at_zero;

   always_comb begin
      ev = 1'b0;
      for (int i = 0; i < NUM_SRC; i++)
         if (act_sel == SEL_W'(i)) ev = src_ev[i];
   end

   assign at_zero = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         act_sel <= '0;
         tick    <= 1'b0;
      end else begin
         tick <= ev && at_zero;
         if (ev) begin
            if (at_zero) begin
               cnt     <= reload_in;
               act_sel <= sel_in;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   assign ev_o      = ev;
   assign act_sel_o = act_sel;
endmodule

// File: rtl/pwm_clkgen_top.sv
module pwm_clkgen_top #(
   parameter int NUM_CH    = 4,
   parameter int NUM_PINS  = 2,
   parameter int RELOAD_W  = 8,
   parameter int SYNC_STG  = 2,
   parameter int TAP_LOG2  = 2,
   parameter int MT_BASE   = 2,
   parameter int MT_STEP   = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   mdiv_sel,
   input  logic [NUM_PINS-1:0]          ext_pin,
   input  logic [NUM_PINS-1:0]          ext_en,
   input  logic [NUM_CH*pwmcg_pkg::SEL_W-1:0] src_sel,
   input  logic [NUM_CH*RELOAD_W-1:0]   reload,
   output logic [NUM_CH-1:0]            ch_tick
);
   import pwmcg_pkg::*;

   if (NUM_CH < 1)                 begin : g_bad_ch   $error("NUM_CH must be at least 1"); end
   if (NUM_PINS < 1)               begin : g_bad_pin  $error("NUM_PINS must be at least 1"); end
   if (NUM_SRC > (1 << SEL_W))     begin : g_bad_sel  $error("select width too small"); end
   if (SYNC_STG < 2)               begin : g_bad_sync $error("SYNC_STG must be at least 2"); end
   if (RELOAD_W < 1)               begin : g_bad_rw   $error("RELOAD_W must be positive"); end

   logic                      mtick;
   logic [NUM_TAPS-1:0]       taps;
   logic [NUM_PINS-1:0]       ext_fall;
   logic [NUM_CH-1:0]         ch_ev;
   logic [NUM_CH*SEL_W-1:0]   act_sel_all;

   pwmcg_mtick #(
      .BASE_LOG2 (MT_BASE),
      .STEP_LOG2 (MT_STEP),
      .NUM_SET   (3)
   ) u_mtick (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_sel (mdiv_sel),
      .mtick   (mtick)
   );

   pwmcg_prescale #(
      .NUM_TAPS (NUM_TAPS),
      .TAP_LOG2 (TAP_LOG2)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .mtick (mtick),
      .taps  (taps)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      pwmcg_pinsync #(.STAGES(SYNC_STG)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (ext_pin[p]),
         .en    (ext_en[p]),
         .fall  (ext_fall[p])
      );
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [NUM_SRC-1:0] src;
      assign src = {ext_fall[c % NUM_PINS], taps};

      pwmcg_chan #(
         .RELOAD_W (RELOAD_W),
         .SEL_W    (SEL_W),
         .NUM_SRC  (NUM_SRC)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .src_ev    (src),
         .sel_in    (src_sel[c*SEL_W +: SEL_W]),
         .reload_in (reload[c*RELOAD_W +: RELOAD_W]),
         .tick      (ch_tick[c]),
         .ev_o      (ch_ev[c]),
         .act_sel_o (act_sel_all[c*SEL_W +: SEL_W])
      );
   end
endmodule

// File: rtl/pwmcg_chk.sv
module pwmcg_chk #(
   parameter int NUM_CH   = 4,
   parameter int NUM_PINS = 2
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [NUM_PINS-1:0]               ext_en,
   input logic [NUM_CH-1:0]                 ch_tick,
   input logic [NUM_CH-1:0]                 ch_ev,
   input logic [NUM_CH*pwmcg_pkg::SEL_W-1:0] act_sel_all,
   input logic [pwmcg_pkg::NUM_TAPS-1:0]    taps
);
   import pwmcg_pkg::*;

   // R2
   tap_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taps[NUM_TAPS-1] |-> (&taps));

   // R10
   rst_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (ch_tick == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      // R9
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ch_tick[c] |=> !ch_tick[c]);

      // R6
      tick_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ch_tick[c] |-> $past(ch_ev[c]));

      // R4
      pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_sel_all[c*SEL_W +: SEL_W] == SRC_EXT && !ext_en[c % NUM_PINS]) |=> !ch_tick[c]);

      // R8
      bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_sel_all[c*SEL_W +: SEL_W] > SRC_EXT) |=> !ch_tick[c]);
   end
endmodule

bind pwm_clkgen_top pwmcg_chk #(
   .NUM_CH   (NUM_CH),
   .NUM_PINS (NUM_PINS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ext_en      (ext_en),
   .ch_tick     (ch_tick),
   .ch_ev       (ch_ev),
   .act_sel_all (act_sel_all),
   .taps        (taps)
);

// File: tb/sim_pwm_clkgen_top.sv
`timescale 1ns/1ps
module sim_pwm_clkgen_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mdiv = 2'd0;
   logic [1:0]  pin = 2'b00;
   logic [1:0]  en = 2'b00;
   logic [2:0]  sel [4];
   logic [7:0]  rld [4];
   logic [11:0] sel_flat;
   logic [31:0] rld_flat;
   logic [3:0]  tick;

   int nvec = 0, nfail = 0, cyc = 0;
   string cur_req = "R9";
   bit pin_run = 1'b0;
   int pdiv = 0;
   int tcnt [4];

   // reference model state
   int  m_mcnt, m_pc;
   int  m_s1 [2], m_s2 [2], m_s3 [2];
   int  m_cnt [4], m_sel [4];
   bit  m_tick [4];

   assign sel_flat = {sel[3], sel[2], sel[1], sel[0]};
   assign rld_flat = {rld[3], rld[2], rld[1], rld[0]};

   always #2 clk = ~clk;

   pwm_clkgen_top u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdiv_sel (mdiv),
      .ext_pin  (pin),
      .ext_en   (en),
      .src_sel  (sel_flat),
      .reload   (rld_flat),
      .ch_tick  (tick)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // behavioural reference, advanced on each rising edge
   always @(posedge clk) begin
      int lim;
      bit mt;
      bit tp [4];
      bit fl [2];
      bit ev;
      cyc++;
      if (!rst_n) begin
         m_mcnt = 0; m_pc = 0;
         for (int p = 0; p < 2; p++) begin m_s1[p] = 0; m_s2[p] = 0; m_s3[p] = 0; end
         for (int c = 0; c < 4; c++) begin m_cnt[c] = 0; m_sel[c] = 0; m_tick[c] = 0; end
      end else begin
         lim = (mdiv == 0) ? 4 : (mdiv == 1) ? 64 : 1024;
         mt = (m_mcnt >= lim - 1);
         tp[0] = mt;
         tp[1] = mt && (m_pc % 4 == 3);
         tp[2] = mt && (m_pc % 16 == 15);
         tp[3] = mt && (m_pc % 64 == 63);
         for (int p = 0; p < 2; p++) fl[p] = en[p] && m_s3[p] == 1 && m_s2[p] == 0;
         for (int c = 0; c < 4; c++) begin
            ev = (m_sel[c] < 4) ? tp[m_sel[c]] : (m_sel[c] == 4) ? fl[c % 2] : 1'b0;
            m_tick[c] = ev && m_cnt[c] == 0;
            if (ev) begin
               if (m_cnt[c] == 0) begin m_cnt[c] = rld[c]; m_sel[c] = sel[c]; end
               else m_cnt[c] = m_cnt[c] - 1;
            end
         end
         for (int p = 0; p < 2; p++) begin m_s3[p] = m_s2[p]; m_s2[p] = m_s1[p]; m_s1[p] = pin[p]; end
         m_mcnt = mt ? 0 : m_mcnt + 1;
         if (mt) m_pc = (m_pc + 1) % 64;
      end
   end

   // per-cycle comparison, tick counting and pin stimulus
   always @(negedge clk) begin
      for (int c = 0; c < 4; c++) begin
         chk(tick[c] == m_tick[c], cur_req, tick[c], m_tick[c]);
         if (tick[c]) tcnt[c]++;
      end
      if (pin_run) begin
         pdiv++;
         if (pdiv == 5) begin pdiv = 0; pin <= ~pin; end
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic window(input int n, output int d [4]);
      int st [4];
      @(negedge clk); #1;
      for (int c = 0; c < 4; c++) st[c] = tcnt[c];
      wait_cyc(n);
      for (int c = 0; c < 4; c++) d[c] = tcnt[c] - st[c];
   endtask

   initial begin
      int d [4];
      int g;
      for (int c = 0; c < 4; c++) begin sel[c] = 3'd0; rld[c] = 8'd0; tcnt[c] = 0; end
      wait_cyc(5);
      // R10: outputs idle during reset
      chk(tick == 4'b0, "R10", tick, 0);
      rst_n = 1'b1;
      wait_cyc(1);
      chk(tick == 4'b0, "R10", tick, 0);

      // R1 R2 R6: all channels on the fastest tap, pass-through
      cur_req = "R1";
      wait_cyc(100);
      window(400, d);
      chk(d[0] == 100, "R1", d[0], 100);
      chk(d[3] == 100, "R6", d[3], 100);

      // R2 R6: tap rates and the /256 reload
      cur_req = "R2";
      sel[0] = 3'd0; rld[0] = 8'd255;
      sel[1] = 3'd1; rld[1] = 8'd0;
      sel[2] = 3'd2; rld[2] = 8'd0;
      sel[3] = 3'd3; rld[3] = 8'd3;
      wait_cyc(2000);
      window(10240, d);
      chk(d[0] == 10,  "R6", d[0], 10);
      chk(d[1] == 640, "R2", d[1], 640);
      chk(d[2] == 160, "R2", d[2], 160);
      chk(d[3] == 10,  "R2", d[3], 10);

      // R1: slower machine tick settings
      cur_req = "R1";
      sel[0] = 3'd0; rld[0] = 8'd0;
      wait_cyc(1100);
      mdiv = 2'd1;
      wait_cyc(2048);
      window(6400, d);
      chk(d[0] == 100, "R1", d[0], 100);
      mdiv = 2'd3;
      wait_cyc(2048);
      window(10240, d);
      chk(d[0] == 10, "R1", d[0], 10);

      // R3 R4 R5 R8: external pins
      cur_req = "R5";
      mdiv = 2'd0;
      en = 2'b01;
      pin_run = 1'b1;
      sel[0] = 3'd4; rld[0] = 8'd2;
      sel[1] = 3'd4; rld[1] = 8'd0;
      sel[2] = 3'd4; rld[2] = 8'd0;
      sel[3] = 3'd5; rld[3] = 8'd0;
      wait_cyc(3000);
      window(1000, d);
      chk(d[2] == 100, "R5", d[2], 100);
      chk(d[0] == 33 || d[0] == 34, "R6", d[0], 33);
      chk(d[1] == 0, "R4", d[1], 0);
      chk(d[3] == 0, "R8", d[3], 0);
      en = 2'b11;
      wait_cyc(20);
      window(1000, d);
      chk(d[1] == 100, "R3", d[1], 100);
      chk(d[3] == 0, "R8", d[3], 0);

      // R7: a reload change waits for the running period to end
      cur_req = "R7";
      sel[1] = 3'd0; rld[1] = 8'd99;
      wait_cyc(1000);
      do begin @(negedge clk); #1; end while (!tick[1]);
      rld[1] = 8'd0;
      g = 0;
      do begin @(negedge clk); #1; g++; end while (!tick[1]);
      chk(g == 400, "R7", g, 400);
      g = 0;
      do begin @(negedge clk); #1; g++; end while (!tick[1]);
      chk(g == 4, "R7", g, 4);

      // R10: reset in mid-run clears the outputs
      cur_req = "R10";
      rst_n = 1'b0;
      wait_cyc(2);
      chk(tick == 4'b0, "R10", tick, 0);
      rst_n = 1'b1;
      wait_cyc(50);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      #(4 * 190000);
      nvec++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule